// File: doc/BRIEF.md
# Monochrome-to-Colour Byte Expander

This block sits in the data path of a 2D blit engine. The host CPU writes monochrome source words into it, one bit per destination pixel. For each bit the block emits as many destination bytes as a pixel occupies. Each byte is taken from the foreground colour when the bit is 1 and from the background colour when the bit is 0. The byte lane of the pixel picks which byte of the colour is used. Downstream logic adds the destination address and the raster operation, and performs the memory write.

A host word carries 8 bits, read from bit 7 downward, or 32 bits, read from bit 31 downward. The host hands the word over with a valid/ready handshake. The block drops ready until every bit of the word has been expanded. Each output byte has a write-enable flag. With transparency on, the flag suppresses the bytes whose source bit is 0, or, when the polarity is inverted, the bytes whose source bit is 1. The colour registers and mode inputs must stay stable while a word is being expanded.

Top module: `mono_color_expander`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `px_valid` and `px_we` are 0 and `hw_ready` is 1.
- R2: `hw_ready` is 1 only when no bits of a word remain. A word is accepted on a clock edge where `hw_valid` and `hw_ready` are both 1. From the next cycle `hw_ready` is 0 until the whole word has been expanded.
- R3: `depth_sel` chooses the bytes per pixel: 0 gives 1 byte (8 bpp), 1 gives 2, 2 gives 3 and 3 gives 4. Every source bit produces exactly that many `px_valid` bytes, on consecutive cycles.
- R4: Byte lane k of a pixel (k counted from 0) outputs bits [8k+7:8k] of `fg_color` when the source bit is 1, and bits [8k+7:8k] of `bg_color` when it is 0.
- R5: The source moves to the next bit only after the last byte lane of the current pixel has been emitted. When `dword_gran` is 0 the word holds 8 bits, taken from bit 7 down to bit 0. When `dword_gran` is 1 it holds 32 bits, taken from bit 31 down to bit 0.
- R6: When `transp_en` is 0, every byte has `px_we` = 1. When `transp_en` is 1 and `transp_inv` is 0, bytes whose source bit is 0 have `px_we` = 0. When both are 1, bytes whose source bit is 1 have `px_we` = 0.
- R7: `hw_valid` is ignored while `hw_ready` is 0. Data offered then does not alter the byte stream of the word already being expanded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hw_valid | input | 1 | Host word offered |
| hw_data | input | 32 | Host monochrome word |
| hw_ready | output | 1 | Block can take a new word |
| dword_gran | input | 1 | 1: 32-bit words, 0: 8-bit words |
| depth_sel | input | 2 | Pixel depth code (0..3 = 1..4 bytes per pixel) |
| fg_color | input | 32 | Foreground colour |
| bg_color | input | 32 | Background colour |
| transp_en | input | 1 | Transparent compare enable |
| transp_inv | input | 1 | Invert the transparency polarity |
| px_valid | output | 1 | Output byte valid |
| px_byte | output | 8 | Output colour byte |
| px_we | output | 1 | Write enable for the output byte |

## Verification
A lane counter that wraps at the wrong point shows up on the very next output byte. The byte comes from the wrong part of a colour, and the bit sequence then slips against the expected sequence. A bit count or a shift register that is off shows up when the word ends. The byte count differs from bits times bytes per pixel, and `hw_ready` returns too early or too late. The scoreboard compares every byte and its write enable in order, so the first wrong byte is reported in the cycle it appears.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic logic [2:0] bytes_per_px(input logic [1:0] depth);
    bytes_per_px = {1'b0, depth} + 3'd1;
  endfunction
endpackage

// File: rtl/cexp_lane_ctr.sv
module cexp_lane_ctr #(
  parameter int unsigned LANES  = 4,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [LANE_W-1:0] last_idx,
  output logic [LANE_W-1:0] lane,
  output logic              last_lane
);
  logic [LANE_W-1:0] lane_q, lane_d;

  always_comb begin
    last_lane = (lane_q >= last_idx);
    lane_d    = lane_q;
    if (step_en) begin
      if (last_lane) lane_d = '0;
      else           lane_d = lane_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= lane_d;
  end

  assign lane = lane_q;

  AST_LANE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && last_lane) |=> (lane_q == '0)); // R5
endmodule

// File: rtl/cexp_bit_src.sv
module cexp_bit_src #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned NARROW_W = 8,
  localparam int unsigned CNT_W   = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] data,
  input  logic              wide,
  input  logic              advance,
  output logic              mask,
  output logic              busy
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  left_q, left_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = data;
      left_d = wide ? CNT_W'(WORD_W) : CNT_W'(NARROW_W);
    end else if (advance) begin
      sh_d   = {sh_q[WORD_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign busy = (left_q != '0);
  assign mask = wide ? sh_q[WORD_W-1] : sh_q[NARROW_W-1];

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !advance) |=> $stable(sh_q)); // R5
endmodule

// File: rtl/cexp_color_out.sv
module cexp_color_out #(
  parameter int unsigned COLOR_W = 32,
  localparam int unsigned LANES  = COLOR_W / cexp_pkg::BYTE_W,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        emit,
  input  logic                        mask,
  input  logic [LANE_W-1:0]           lane,
  input  logic [COLOR_W-1:0]          fg,
  input  logic [COLOR_W-1:0]          bg,
  input  logic                        t_en,
  input  logic                        t_inv,
  output logic                        o_valid,
  output logic [cexp_pkg::BYTE_W-1:0] o_byte,
  output logic                        o_we
);
  localparam int unsigned BW = cexp_pkg::BYTE_W;

  logic [BW-1:0] fg_lane [LANES];
  logic [BW-1:0] bg_lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign fg_lane[g] = fg[g*BW +: BW];
    assign bg_lane[g] = bg[g*BW +: BW];
  end

  logic          valid_d, we_d;
  logic [BW-1:0] byte_d;

  always_comb begin
    valid_d = emit;
    byte_d  = mask ? fg_lane[lane] : bg_lane[lane];
    we_d    = emit && !(t_en && (mask == t_inv));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_byte  <= '0;
      o_we    <= 1'b0;
    end else begin
      o_valid <= valid_d;
      o_we    <= we_d;
      if (emit) o_byte <= byte_d;
    end
  end

  AST_OPAQUE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !t_en) |=> o_we); // R6
endmodule

// File: rtl/mono_color_expander.sv
module mono_color_expander #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned COLOR_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hw_valid,
  input  logic [WORD_W-1:0]           hw_data,
  output logic                        hw_ready,
  input  logic                        dword_gran,
  input  logic [1:0]                  depth_sel,
  input  logic [COLOR_W-1:0]          fg_color,
  input  logic [COLOR_W-1:0]          bg_color,
  input  logic                        transp_en,
  input  logic                        transp_inv,
  output logic                        px_valid,
  output logic [cexp_pkg::BYTE_W-1:0] px_byte,
  output logic                        px_we
);
  localparam int unsigned LANES  = COLOR_W / cexp_pkg::BYTE_W;
  localparam int unsigned LANE_W = $clog2(LANES);

  logic              busy, mask, load, last_lane;
  logic [LANE_W-1:0] lane, last_idx;

  always_comb begin
    last_idx = LANE_W'(cexp_pkg::bytes_per_px(depth_sel) - 3'd1);
    hw_ready = !busy;
    load     = hw_valid && hw_ready;
  end

  cexp_lane_ctr #(.LANES(LANES)) u_lane (
    .clk(clk), .rst_n(rst_n), .step_en(busy), .last_idx(last_idx),
    .lane(lane), .last_lane(last_lane)
  );

  cexp_bit_src #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .data(hw_data), .wide(dword_gran),
    .advance(busy && last_lane), .mask(mask), .busy(busy)
  );

  cexp_color_out #(.COLOR_W(COLOR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .emit(busy), .mask(mask), .lane(lane),
    .fg(fg_color), .bg(bg_color), .t_en(transp_en), .t_inv(transp_inv),
    .o_valid(px_valid), .o_byte(px_byte), .o_we(px_we)
  );

  AST_VALID_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> $past(!hw_ready)); // R2
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && hw_ready) |=> !hw_ready); // R2
endmodule

// File: tb/sim_mono_color_expander.sv
module sim_mono_color_expander;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hw_valid;
  logic [31:0] hw_data;
  logic        hw_ready;
  logic        dword_gran;
  logic [1:0]  depth_sel;
  logic [31:0] fg_color, bg_color;
  logic        transp_en, transp_inv;
  logic        px_valid, px_we;
  logic [7:0]  px_byte;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [8:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mono_color_expander u0 (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
    .hw_ready(hw_ready), .dword_gran(dword_gran), .depth_sel(depth_sel),
    .fg_color(fg_color), .bg_color(bg_color), .transp_en(transp_en),
    .transp_inv(transp_inv), .px_valid(px_valid), .px_byte(px_byte), .px_we(px_we)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected {we,byte} items as bytes appear (R3 R4 R5 R6)
  always @(negedge clk) begin
    if (rst_n && px_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected byte", {23'd0, px_we, px_byte}, 32'h0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({px_we, px_byte} === e, "R4 R5 R6 byte/we", {23'd0, px_we, px_byte},
              {23'd0, e});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic push_expected(input logic [31:0] data);
    int nbits = dword_gran ? 32 : 8;
    int nby   = int'(depth_sel) + 1;
    for (int i = 0; i < nbits; i++) begin
      logic m;
      logic [31:0] col;
      m   = data[nbits-1-i];
      col = m ? fg_color : bg_color;
      for (int l = 0; l < nby; l++)
        exp_q.push_back({!(transp_en && (m == transp_inv)), col[8*l +: 8]});
    end
  endtask

  task automatic send_word(input logic [31:0] data, input bit junk);
    @(negedge clk);
    while (!hw_ready) @(negedge clk);
    push_expected(data);
    hw_valid = 1'b1;
    hw_data  = data;
    @(negedge clk);
    hw_valid = 1'b0;
    check(hw_ready == 1'b0, "R2 ready drops after accept", {31'd0, hw_ready}, 32'd0);
    if (junk) begin
      // R7: offers while busy must be ignored (word is 8 bits, 1 byte each)
      hw_valid = 1'b1;
      hw_data  = ~data;
      repeat (3) @(negedge clk);
      hw_valid = 1'b0;
    end
  endtask

  task automatic configure(input logic [1:0] d, input bit g, input bit te,
                           input bit ti);
    @(negedge clk);
    while (!hw_ready) @(negedge clk);
    depth_sel = d; dword_gran = g; transp_en = te; transp_inv = ti;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_q.size() != 0 || !hw_ready) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(hw_ready == 1'b1, "R2 ready back after word", {31'd0, hw_ready}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; hw_valid = 1'b0; hw_data = '0;
    dword_gran = 1'b0; depth_sel = 2'd0;
    fg_color = 32'h4433_2211; bg_color = 32'h8877_6655;
    transp_en = 1'b0; transp_inv = 1'b0;
    repeat (3) @(negedge clk);
    check(px_valid == 1'b0 && px_we == 1'b0, "R1 outputs idle in reset",
          {30'd0, px_valid, px_we}, 32'd0);
    check(hw_ready == 1'b1, "R1 ready in reset", {31'd0, hw_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(px_valid == 1'b0 && hw_ready == 1'b1, "R1 idle after reset",
          {30'd0, px_valid, hw_ready}, 32'd1);

    configure(2'd0, 1'b0, 1'b0, 1'b0);
    send_word(32'h0000_00A5, 1'b1);     // R7 junk offered while busy
    drain("R3 R7 8bpp byte word");

    configure(2'd1, 1'b0, 1'b0, 1'b0);
    send_word(32'h0000_003C, 1'b0);
    drain("R3 16bpp");

    configure(2'd2, 1'b0, 1'b1, 1'b0);
    send_word(32'h0000_0096, 1'b0);
    drain("R6 24bpp transparent");

    configure(2'd3, 1'b1, 1'b1, 1'b1);
    send_word(32'hF00F_1234, 1'b0);
    drain("R5 R6 32bpp dword inverted");

    fg_color = 32'hDEAD_BEEF; bg_color = 32'h0102_0304;
    configure(2'd2, 1'b1, 1'b0, 1'b0);
    send_word(32'h8000_0001, 1'b0);
    drain("R5 24bpp dword edge bits");

    configure(2'd0, 1'b1, 1'b0, 1'b0);
    send_word(32'h1234_5678, 1'b0);
    send_word(32'hCAFE_0001, 1'b0);
    drain("R2 R3 back to back");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule